// File: doc/BRIEF.md
# Linear Burst Master with Address Hold

This block sequences linear burst transfers on a word-addressed bus. A one-cycle start pulse hands it an address, a direction and a line-length code. The block then runs an address cycle that pulses the address strobe. Four data beats follow, one on each beat-ready. On every beat the two lowest word-address bits step forward in linear order, wrapping within the line.

An external snoop agent can raise an address-hold input at any time. The cycle after the block samples it high, the block stops driving the upper address bits picked by the latched line-length code. The data beats of a burst already in flight keep going. What the hold blocks is the start of any new address phase. If a start request, an address cycle that the hold overlapped, or a restart forced by the restart input meets an active hold, the block parks in a wait cycle. In that cycle the command stays driven and the strobe stays low. The block issues the address cycle with the same intended address once the hold is sampled low.

Top module: `burst_master_ahold`

## Requirements
- R1: After reset the strobe, command-valid, done and error outputs are 0, every address output enable is 1, and the latched line-length code is 5'b00100.
- R2: The strobe `ads` is high only in a cycle whose opening clock edge sampled `ahold` low.
- R3: One cycle after `ahold` is sampled high, the enables of the floated bits drop to 0 and the rest stay 1. One cycle after `ahold` is sampled low, all enables are 1.
- R4: Floated range by code (index 0 is A2): 00000 none, 00001 indices 29..0, 00010 indices 29..1, 00100 indices 29..2, 01000 indices 29..3, 10000 indices 29..4.
- R5: Any other code floats indices 29..0 and sets `len_err` when latched at a burst start. `len_err` then stays set until reset.
- R6: The line-length code is latched only when a start pulse is accepted. A change later in the burst does not alter the floated range.
- R7: A burst has four data beats. Each `brdy` in a data cycle adds 1 modulo 4 to address bits [1:0], and the fourth `brdy` raises `burst_done` combinationally in that cycle.
- R8: `ahold` in a data cycle does not stall beats: each `brdy` there is taken.
- R9: If `ahold` is sampled high at the end of an address cycle, that cycle is void. The block waits with `cmd_valid` high, `ads` low and the address unchanged, then repeats the address cycle after `ahold` is sampled low.
- R10: A start pulse accepted while `ahold` is high leads to a wait cycle with `cmd_valid` high and `ads` low, and the address cycle follows the first edge at which `ahold` is low.
- R11: `rdyrtn` in a data cycle that does not end the burst forces a new address cycle at the current address, or a wait cycle if `ahold` is high.
- R12: A start pulse while a burst is in progress is ignored: address, direction and latched code are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_go | input | 1 | One-cycle burst start pulse |
| req_addr | input | 30 | Word address of the first beat (A31..A2) |
| req_wr | input | 1 | Direction, 1 = write |
| line_len | input | 5 | Line-length code, latched at burst start |
| ahold | input | 1 | Address hold request |
| brdy | input | 1 | Beat ready |
| rdyrtn | input | 1 | Force a new address cycle |
| ads | output | 1 | Address strobe |
| cmd_valid | output | 1 | Command signals driven |
| cmd_wr | output | 1 | Driven direction |
| addr | output | 30 | Address bits A31..A2 |
| addr_oe | output | 30 | Per-bit address output enable |
| burst_done | output | 1 | Last beat accepted this cycle |
| len_err | output | 1 | Sticky reserved-code flag |

## Verification
The bench builds the block with its defaults: a 30-bit word address, a 5-bit line-length code and four beats. With these values every legal code and several reserved codes can be latched, so each float boundary from A2 to A6 and the full-float fallback can be seen on the enables. The 2-bit beat counter also wraps when a burst starts on a nonzero offset. A behavioural model tracks the expected state on every clock while the hold is moved into address cycles, wait cycles, data cycles and forced restarts.

// File: rtl/burst_master_ahold.sv
module burst_master_ahold #(
  parameter int AW = 30,
  parameter int LW = 5,
  parameter int BEATS = 4,
  parameter logic [LW-1:0] LEN_RST = LW'(4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_go,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wr,
  input  logic [LW-1:0] line_len,
  input  logic          ahold,
  input  logic          brdy,
  input  logic          rdyrtn,
  output logic          ads,
  output logic          cmd_valid,
  output logic          cmd_wr,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] addr_oe,
  output logic          burst_done,
  output logic          len_err
);
  localparam int BW = $clog2(BEATS);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_HOLD} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic [BW-1:0] beat_q;
  logic          wr_q, err_q, ah_q;
  logic          last;
  logic          floating;
  int            lo;
  logic [AW-1:0] fmask;

  function automatic logic len_ok(input logic [LW-1:0] v);
    return (v == '0) || $onehot(v);
  endfunction

  assign last       = beat_q == BW'(BEATS - 1);
  assign ads        = st == S_ADDR;
  assign cmd_valid  = st != S_IDLE;
  assign cmd_wr     = wr_q;
  assign addr       = addr_q;
  assign burst_done = (st == S_DATA) && brdy && last;
  assign len_err    = err_q;
  assign addr_oe    = ah_q ? ~fmask : '1;

  always_comb begin
    lo = 0;
    floating = 1'b1;
    if (len_q == '0) floating = 1'b0;
    else if ($onehot(len_q))
      for (int i = 0; i < LW; i++)
        if (len_q[i]) lo = i;
    for (int j = 0; j < AW; j++) fmask[j] = floating && (j >= lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      len_q  <= LEN_RST;
      beat_q <= '0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      ah_q   <= 1'b0;
    end else begin
      ah_q <= ahold;
      case (st)
        S_IDLE: if (req_go) begin
          addr_q <= req_addr;
          wr_q   <= req_wr;
          len_q  <= line_len;
          beat_q <= '0;
          if (!len_ok(line_len)) err_q <= 1'b1;
          st <= ahold ? S_HOLD : S_ADDR;
        end
        S_ADDR: st <= ahold ? S_HOLD : S_DATA;
        S_HOLD: if (!ahold) st <= S_ADDR;
        S_DATA: begin
          if (brdy) begin
            addr_q[BW-1:0] <= addr_q[BW-1:0] + BW'(1);
            beat_q <= beat_q + BW'(1);
          end
          if (brdy && last) st <= S_IDLE;
          else if (rdyrtn) st <= ahold ? S_HOLD : S_ADDR;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module burst_master_ahold_chk #(
  parameter int AW = 30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ahold,
  input logic          brdy,
  input logic          ads,
  input logic          cmd_valid,
  input logic          burst_done,
  input logic          len_err,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] addr_oe
);
  assert_ads_hold_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ads |-> !$past(ahold));

  assert_oe_restored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ahold) |-> (&addr_oe));

  assert_void_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ads) && $past(ahold)) |-> (cmd_valid && !ads && $stable(addr)));

  assert_done_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (brdy && cmd_valid && !ads));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(len_err) |-> len_err);
endmodule

bind burst_master_ahold burst_master_ahold_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ahold(ahold), .brdy(brdy), .ads(ads),
  .cmd_valid(cmd_valid), .burst_done(burst_done), .len_err(len_err),
  .addr(addr), .addr_oe(addr_oe)
);

// File: tb/burst_master_ahold_bench.sv
module burst_master_ahold_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_go = 0, req_wr = 0, ahold = 0, brdy = 0, rdyrtn = 0;
  logic [29:0] req_addr = '0;
  logic [4:0]  line_len = 5'd4;
  logic ads, cmd_valid, cmd_wr, burst_done, len_err;
  logic [29:0] addr, addr_oe;

  int total = 0, bad = 0;
  string scen = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  burst_master_ahold u_burst_master_ahold (
    .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_addr(req_addr),
    .req_wr(req_wr), .line_len(line_len), .ahold(ahold), .brdy(brdy),
    .rdyrtn(rdyrtn), .ads(ads), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
    .addr(addr), .addr_oe(addr_oe), .burst_done(burst_done), .len_err(len_err)
  );

  // model: 0 idle, 1 address cycle, 2 data, 3 wait
  int mst = 0, mbeat = 0;
  logic [29:0] maddr = '0;
  logic [4:0]  mlen = 5'd4;
  bit mwr = 0, merr = 0, mah = 0;

  function automatic bit legal(logic [4:0] l);
    return l inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd16};
  endfunction

  function automatic logic [29:0] exp_oe(logic [4:0] l, bit ah);
    int k;
    if (!ah || l == 0) return '1;
    case (l)
      5'd2: k = 1; 5'd4: k = 2; 5'd8: k = 3; 5'd16: k = 4;
      default: k = 0;
    endcase
    return (30'd1 << k) - 30'd1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; mbeat = 0; maddr = '0; mlen = 5'd4; mwr = 0; merr = 0; mah = 0;
    end else begin
      int nst;
      nst = mst;
      if (mst == 0 && req_go) begin
        maddr = req_addr; mwr = req_wr; mlen = line_len; mbeat = 0;
        if (!legal(line_len)) merr = 1;
        nst = ahold ? 3 : 1;
      end else if (mst == 1) nst = ahold ? 3 : 2;
      else if (mst == 3) begin if (!ahold) nst = 1; end
      else if (mst == 2) begin
        if (brdy) begin
          maddr[1:0] = maddr[1:0] + 2'd1;
          mbeat++;
        end
        if (brdy && mbeat == 4) nst = 0;
        else if (rdyrtn) nst = ahold ? 3 : 1;
      end
      mst = nst;
      mah = ahold;
    end
  end

  task automatic chk(input logic [29:0] act, input logic [29:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s) actual=%h expected=%h at %0t", what, scen, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(30'(ads), 30'(mst == 1), "R2 ads");
    chk(addr_oe, exp_oe(mlen, mah), "R3 R4 addr_oe");
    chk(30'(cmd_valid), 30'(mst != 0), "R10 cmd_valid");
    chk(30'(burst_done), 30'(mst == 2 && brdy && mbeat == 3), "R7 burst_done");
    chk(30'(len_err), 30'(merr), "R5 len_err");
    if (mst != 0) begin
      chk(addr, maddr, "R7 addr");
      chk(30'(cmd_wr), 30'(mwr), "R12 cmd_wr");
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1 compare_all();
    end
  endtask

  task automatic start(input logic [29:0] a, input bit wr, input logic [4:0] l);
    req_go = 1; req_addr = a; req_wr = wr; line_len = l;
    tick();
    req_go = 0;
  endtask

  task automatic beats(input int n);
    brdy = 1; tick(n); brdy = 0;
  endtask

  initial begin
    #200000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    scen = "R1";
    chk(30'(ads), 0, "R1 ads"); chk(30'(cmd_valid), 0, "R1 cmd_valid");
    chk(addr_oe, '1, "R1 addr_oe"); chk(30'(len_err), 0, "R1 len_err");
    rst_n = 1;
    tick(2);
    ahold = 1; tick(2); ahold = 0; tick(2);   // default code floats 29..2

    scen = "R7";
    start(30'h1234_5672, 1, 5'd4);
    tick(); beats(2); tick(); beats(2); tick(2);

    scen = "R8";
    start(30'h0AAA_0001, 0, 5'd8);
    tick(); ahold = 1; beats(4); tick(); ahold = 0; tick(2);

    scen = "R9";
    start(30'h0000_0F03, 1, 5'd2);
    ahold = 1; tick(3); ahold = 0; tick(2); beats(4); tick(2);

    scen = "R10";
    ahold = 1; start(30'h2000_0000, 0, 5'd16);
    tick(2); ahold = 0; tick(2); beats(4); tick();

    scen = "R11";
    start(30'h0100_0100, 1, 5'd1);
    tick(); brdy = 1; rdyrtn = 1; tick(); brdy = 0; rdyrtn = 0;
    tick(2); beats(1);
    rdyrtn = 1; ahold = 1; tick(); rdyrtn = 0; tick(2); ahold = 0; tick(2);
    beats(2); tick(2);

    scen = "R6";
    start(30'h0300_0002, 0, 5'd0);
    line_len = 5'd1; tick(); ahold = 1; brdy = 1; tick(2);
    line_len = 5'd16; tick(2); brdy = 0; ahold = 0; tick(2);

    scen = "R4";
    foreach (line_len[i]) begin
      start(30'h1555_5554 + 30'(i), i[0], 5'd1 << i);
      tick(); ahold = 1; beats(4); ahold = 0; tick(2);
    end

    scen = "R5";
    start(30'h0000_0011, 1, 5'd3);
    tick(); ahold = 1; beats(4); ahold = 0; tick();
    start(30'h0000_0020, 0, 5'd4);
    tick(); ahold = 1; tick(); beats(4); ahold = 0; tick(2);
    start(30'h0000_0030, 0, 5'd24);
    tick(); beats(4); tick();

    scen = "R12";
    start(30'h0F0F_0F00, 1, 5'd8);
    tick(); beats(1);
    req_go = 1; req_addr = 30'h3000_0003; req_wr = 0; line_len = 5'd1;
    tick(2); req_go = 0;
    ahold = 1; beats(3); ahold = 0; tick(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule